// File: doc/BRIEF.md
# Programmable-Priority Memory Request Arbiter

This block picks which of four initiators may next use a shared memory interface: a PCI initiator, an external parallel-port initiator, a general-purpose DMA initiator and a CPU buffer path. When the arbiter is idle and at least one request is present, it issues a registered one-hot grant. The granted initiator keeps the grant until it drops its request or pulses end-of-transfer. The arbiter then spends one cycle with no grant and picks again.

Each initiator has a 2-bit rank, and the highest rank wins. Software sets the ranks through a small word-addressed register port. The PCI, external-port and DMA initiators each also have a programmable wait limit, and each of these three limits can be switched on or off on its own. An initiator with its limit switched on that has waited at least its limit takes precedence over the plain rank order. The CPU path has no wait limit. It is still arbitrated, so it is never locked out when the other initiators are quiet.

Top module: `mem_req_arbiter`

## Requirements
- R1: After reset `gnt` is 0. The registers read back as follows: latency-enable 0x0, CPU rank 0x0, PCI config 0xFF03, external-port config 0xFF02 and DMA config 0xFF01. This means all limits are 0xFF and the default ranks are PCI=3, external=2, DMA=1, CPU=0.
- R2: With default settings and several requests present, the grant order is PCI, then external port, then DMA, then CPU. The `req`/`gnt` bit order is 0=PCI, 1=external, 2=DMA, 3=CPU.
- R3: `gnt` is always one-hot or zero. When `gnt` is 0 and `req` is nonzero at a clock edge, `gnt` holds exactly one of the bits that were requesting after that edge.
- R4: A grant is held while its owner keeps `req` high and `eot` low. At the first edge where the owner has `req` low or `eot` high, `gnt` becomes 0.
- R5: The winner is the requesting initiator with the numerically largest rank. The CPU rank is bits [1:0] at offset 1. The other ranks are bits [1:0] of their config words.
- R6: When the highest rank is shared by several requesters, the lowest bit index among them wins.
- R7: Each of the PCI, external-port and DMA initiators has a wait counter. The counter counts the edges at which the initiator requests without holding the grant. It clears otherwise and saturates at 255. If the initiator's enable bit is set and its count is at least its limit, it beats every non-urgent requester. The limit is bits [15:8] of its config word.
- R8: When several initiators are urgent at the same time, the rank order (with the R6 tie rule) decides among them alone.
- R9: With an enable bit clear, a long wait has no effect and arbitration follows rank only. The CPU path has no limit.
- R10: The register map uses word offsets: 0 = latency enables (bit0 PCI, bit1 external, bit2 DMA), 1 = CPU rank, 2/3/4 = PCI/external/DMA config. Unused bits read 0. Offsets 5 to 7 read 0, and writes to them change nothing. A write takes effect at the next edge.
- R11: A CPU request made while the arbiter is idle and no other initiator is requesting is granted at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 4 | Requests: 0=PCI, 1=external port, 2=DMA, 3=CPU |
| eot | input | 4 | End-of-transfer pulse from each initiator |
| gnt | output | 4 | Registered one-hot grant |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |

## Verification
The hardest case to reach is two urgent initiators whose rank order is the opposite of the order in which they started waiting. This needs the counters to run past their limits while something else holds the memory. The stimulus first hands the grant to a CPU path that has been given the top rank and makes it hold for several cycles while PCI and DMA wait. It then releases the CPU path, so the next pick happens with the chosen counters already over their limits. A long random phase then mixes requests, end-of-transfer pulses and register writes, and a behavioural model checks the grant on every cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;
   localparam int N_REQ = 4;
   localparam int N_LAT = 3;

   localparam int IDX_PCI = 0;
   localparam int IDX_EXT = 1;
   localparam int IDX_DMA = 2;
   localparam int IDX_CPU = 3;

   localparam int OFF_LAT_EN   = 0;
   localparam int OFF_CPU_RANK = 1;
   localparam int OFF_CFG_BASE = 2;
   localparam int N_MAPPED     = OFF_CFG_BASE + N_LAT;

   function automatic int dflt_rank(input int idx);
      return N_REQ - 1 - idx;
   endfunction
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
   import arb_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 32,
   parameter int RANK_W  = 2,
   parameter int LAT_W   = 8,
   parameter int LIM_LSB = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [DATA_W-1:0]                wdata,
   output logic [DATA_W-1:0]                rdata,
   output logic [N_LAT-1:0]                 lat_en,
   output logic [N_REQ-1:0][RANK_W-1:0]     rank,
   output logic [N_LAT-1:0][LAT_W-1:0]      lim
);
   localparam logic [LAT_W-1:0] LIM_RST = '1;

   if (LIM_LSB < RANK_W) begin : g_bad_lsb
      $error("limit field overlaps rank field");
   end
   if (LIM_LSB + LAT_W > DATA_W) begin : g_bad_width
      $error("limit field exceeds data width");
   end
   if ((1 << ADDR_W) < N_MAPPED) begin : g_bad_addr
      $error("address too narrow for register map");
   end

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^wdata;

   logic [N_LAT-1:0]  en_q;
   logic [RANK_W-1:0] cpu_rank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= '0;
         cpu_rank_q <= RANK_W'(dflt_rank(IDX_CPU));
      end else if (we) begin
         if (addr == ADDR_W'(OFF_LAT_EN))   en_q       <= wdata[N_LAT-1:0];
         if (addr == ADDR_W'(OFF_CPU_RANK)) cpu_rank_q <= wdata[RANK_W-1:0];
      end
   end

   assign lat_en       = en_q;
   assign rank[IDX_CPU] = cpu_rank_q;

   for (genvar k = 0; k < N_LAT; k++) begin : g_cfg
      logic [RANK_W-1:0] r_q;
      logic [LAT_W-1:0]  l_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_q <= RANK_W'(dflt_rank(k));
            l_q <= LIM_RST;
         end else if (we && addr == ADDR_W'(OFF_CFG_BASE + k)) begin
            r_q <= wdata[RANK_W-1:0];
            l_q <= wdata[LIM_LSB +: LAT_W];
         end
      end
      assign rank[k] = r_q;
      assign lim[k]  = l_q;
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFF_LAT_EN))   rdata[N_LAT-1:0]  = en_q;
      if (addr == ADDR_W'(OFF_CPU_RANK)) rdata[RANK_W-1:0] = cpu_rank_q;
      for (int i = 0; i < N_LAT; i++) begin
         if (addr == ADDR_W'(OFF_CFG_BASE + i)) begin
            rdata[RANK_W-1:0]       = rank[i];
            rdata[LIM_LSB +: LAT_W] = lim[i];
         end
      end
   end

   a_r10_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(OFF_LAT_EN)) |=> (lat_en == $past(wdata[N_LAT-1:0])));

   a_r10_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(addr) >= N_MAPPED) |=> ($stable(lat_en) && $stable(rank) && $stable(lim)));
endmodule

// File: rtl/arb_wait_ctr.sv
module arb_wait_ctr #(
   parameter int LAT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pend,
   input  logic             en,
   input  logic [LAT_W-1:0] lim,
   output logic             urgent
);
   localparam logic [LAT_W-1:0] CNT_MAX = '1;

   if (LAT_W < 1) begin : g_bad_w
      $error("counter width must be positive");
   end

   logic [LAT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!pend)          cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + LAT_W'(1);
   end

   assign urgent = en && pend && (cnt >= lim);

   a_r7_clear_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !pend |=> (cnt == '0));

   a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && cnt != CNT_MAX) |=> (cnt == $past(cnt) + LAT_W'(1)));

   a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/arb_pick.sv
module arb_pick
   import arb_pkg::*;
#(
   parameter int RANK_W = 2
) (
   input  logic [N_REQ-1:0]             req,
   input  logic [N_LAT-1:0]             urgent,
   input  logic [N_REQ-1:0][RANK_W-1:0] rank,
   output logic [N_REQ-1:0]             win
);
   logic [N_REQ-1:0]  urg_mask;
   logic [N_REQ-1:0]  cand;
   logic [RANK_W-1:0] best_rank;
   logic              found;

   always_comb begin
      urg_mask = '0;
      urg_mask[N_LAT-1:0] = urgent & req[N_LAT-1:0];
      cand      = (|urg_mask) ? urg_mask : req;
      win       = '0;
      best_rank = '0;
      found     = 1'b0;
      for (int i = 0; i < N_REQ; i++) begin
         if (cand[i] && (!found || rank[i] > best_rank)) begin
            win       = N_REQ'(1) << i;
            best_rank = rank[i];
            found     = 1'b1;
         end
      end
   end

   always_comb begin
      a_r3_win_onehot: assert ($onehot0(win));
      a_r3_win_requested: assert ((win & ~req) == '0);
      a_r3_win_present: assert ((req == '0) || (win != '0));
   end
endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter
   import arb_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 32,
   parameter int RANK_W  = 2,
   parameter int LAT_W   = 8,
   parameter int LIM_LSB = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        req,
   input  logic [3:0]        eot,
   output logic [3:0]        gnt,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);
   if (N_REQ != 4) begin : g_bad_n
      $error("port widths assume four requesters");
   end
   if ((1 << RANK_W) < N_REQ) begin : g_bad_rank
      $error("rank too narrow for distinct defaults");
   end

   logic [N_LAT-1:0]             lat_en;
   logic [N_REQ-1:0][RANK_W-1:0] rank;
   logic [N_LAT-1:0][LAT_W-1:0]  lim;
   logic [N_LAT-1:0]             urgent;
   logic [N_REQ-1:0]             win;
   logic [N_REQ-1:0]             rel;

   arb_cfg_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RANK_W(RANK_W),
      .LAT_W(LAT_W), .LIM_LSB(LIM_LSB)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .lat_en(lat_en), .rank(rank), .lim(lim)
   );

   for (genvar k = 0; k < N_LAT; k++) begin : g_wait
      arb_wait_ctr #(.LAT_W(LAT_W)) u_ctr (
         .clk(clk), .rst_n(rst_n),
         .pend(req[k] & ~gnt[k]),
         .en(lat_en[k]), .lim(lim[k]),
         .urgent(urgent[k])
      );
   end

   arb_pick #(.RANK_W(RANK_W)) u_pick (
      .req(req), .urgent(urgent), .rank(rank), .win(win)
   );

   assign rel = gnt & (~req | eot);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              gnt <= '0;
      else if (gnt != '0) begin
         if (rel != '0)        gnt <= '0;
      end else                 gnt <= win;
   end

   a_r3_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   a_r3_idle_serves: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req != '0) |=> ((gnt & $past(req)) != '0));

   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0 && (gnt & (~req | eot)) == '0) |=> (gnt == $past(gnt)));

   a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt & (~req | eot)) != '0) |=> (gnt == '0));

   a_r11_cpu_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt == '0 && req == 4'b1000) |=> (gnt == 4'b1000));
endmodule

// File: tb/mem_req_arbiter_bench.sv
module mem_req_arbiter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  req = '0;
   logic [3:0]  eot = '0;
   logic [3:0]  gnt;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   string tag = "R1";

   always #5 clk = ~clk;

   mem_req_arbiter u_mem_req_arbiter (
      .clk(clk), .rst_n(rst_n), .req(req), .eot(eot), .gnt(gnt),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   // behavioural reference model
   int       m_rank[4];
   int       m_lim[3];
   int       m_cnt[3];
   bit [2:0] m_en;
   bit [3:0] m_gnt;

   task automatic model_reset();
      m_en = '0;
      m_gnt = '0;
      for (int i = 0; i < 4; i++) m_rank[i] = 3 - i;
      for (int i = 0; i < 3; i++) begin m_lim[i] = 255; m_cnt[i] = 0; end
   endtask

   function automatic bit [3:0] model_pick(input bit [3:0] r);
      bit [3:0] u = '0;
      bit [3:0] c;
      int best = -1;
      for (int i = 0; i < 3; i++)
         if (m_en[i] && r[i] && m_cnt[i] >= m_lim[i]) u[i] = 1'b1;
      c = (u != 0) ? u : r;
      for (int i = 0; i < 4; i++)
         if (c[i] && (best < 0 || m_rank[i] > m_rank[best])) best = i;
      return (best < 0) ? 4'b0 : 4'(1 << best);
   endfunction

   initial model_reset();

   always @(posedge clk) begin
      bit [3:0] ng;
      if (!rst_n) model_reset();
      else begin
         if (m_gnt != 0) ng = ((m_gnt & (~req | eot)) != 0) ? 4'b0 : m_gnt;
         else            ng = model_pick(req);
         for (int i = 0; i < 3; i++) begin
            if (req[i] && !m_gnt[i]) begin
               if (m_cnt[i] < 255) m_cnt[i]++;
            end else m_cnt[i] = 0;
         end
         if (reg_we) begin
            case (reg_addr)
               3'd0: m_en = reg_wdata[2:0];
               3'd1: m_rank[3] = int'(reg_wdata[1:0]);
               3'd2, 3'd3, 3'd4: begin
                  m_rank[reg_addr - 2] = int'(reg_wdata[1:0]);
                  m_lim[reg_addr - 2]  = int'(reg_wdata[15:8]);
               end
               default: ;
            endcase
         end
         m_gnt = ng;
      end
   end

   task automatic check(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h at %0t", t, act, exp, $time);
      end
   endtask

   always @(negedge clk)
      if (rst_n && !done) check(gnt === m_gnt, {tag, " model"}, 32'(gnt), 32'(m_gnt));

   task automatic step(input logic [3:0] r, input logic [3:0] e);
      @(negedge clk);
      req = r;
      eot = e;
   endtask

   task automatic expect_gnt(input logic [3:0] exp, input string t);
      check(gnt === exp, t, 32'(gnt), 32'(exp));
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string t);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(reg_rdata === exp, t, reg_rdata, exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      req = '0; eot = '0; reg_we = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // request r from idle; expect winner, then return to idle
   task automatic burst(input logic [3:0] r, input logic [3:0] exp, input string t);
      step(r, 4'b0);
      step(r, 4'b0);
      expect_gnt(exp, t);
      step(4'b0, 4'b0);
      step(4'b0, 4'b0);
      expect_gnt(4'b0, t);
   endtask

   // CPU owns the grant for a while, then others compete with aged counters
   task automatic aged_contest(input logic [3:0] others, input logic [3:0] exp, input string t);
      step(4'b1000, 4'b0);
      repeat (5) step(4'b1000 | others, 4'b0);
      step(others, 4'b0);
      step(others, 4'b0);
      step(others, 4'b0);
      expect_gnt(exp, t);
      step(4'b0, 4'b0);
      step(4'b0, 4'b0);
      step(4'b0, 4'b0);
   endtask

   initial begin
      do_reset();
      tag = "R1";
      expect_gnt(4'b0, "R1 gnt after reset");
      rd(3'd0, 32'h0, "R1 enable reset");
      rd(3'd1, 32'h0, "R1 cpu rank reset");
      rd(3'd2, 32'hFF03, "R1 pci cfg reset");
      rd(3'd3, 32'hFF02, "R1 ext cfg reset");
      rd(3'd4, 32'hFF01, "R1 dma cfg reset");

      tag = "R2";
      step(4'b1111, 4'b0);
      step(4'b1111, 4'b0001);
      expect_gnt(4'b0001, "R2 pci first");
      step(4'b1110, 4'b0);
      expect_gnt(4'b0000, "R4 eot releases");
      step(4'b1110, 4'b0);
      expect_gnt(4'b0010, "R2 ext second");
      step(4'b1100, 4'b0);
      expect_gnt(4'b0010, "R4 held while requesting");
      step(4'b1100, 4'b0);
      expect_gnt(4'b0000, "R4 req drop releases");
      step(4'b1000, 4'b0);
      expect_gnt(4'b0100, "R2 dma third");
      step(4'b1000, 4'b0);
      expect_gnt(4'b0000, "R4 dma released");
      step(4'b0, 4'b0);
      expect_gnt(4'b1000, "R11 cpu alone granted");
      step(4'b0, 4'b0);
      expect_gnt(4'b0000, "R4 cpu released");

      tag = "R5";
      wr(3'd1, 32'h3);
      wr(3'd2, 32'hFF00);
      burst(4'b1111, 4'b1000, "R5 cpu top rank");
      burst(4'b0111, 4'b0010, "R5 ext rank 2");
      burst(4'b0101, 4'b0100, "R5 dma over pci");

      tag = "R6";
      wr(3'd1, 32'h1);
      wr(3'd2, 32'hFF01);
      wr(3'd3, 32'hFF01);
      wr(3'd4, 32'hFF01);
      burst(4'b1110, 4'b0010, "R6 tie lowest index ext");
      burst(4'b1100, 4'b0100, "R6 tie dma over cpu");
      burst(4'b1001, 4'b0001, "R6 tie pci over cpu");

      tag = "R9";
      do_reset();
      wr(3'd1, 32'h3);
      wr(3'd2, 32'h0302);
      wr(3'd3, 32'h0301);
      wr(3'd4, 32'h0300);
      aged_contest(4'b0101, 4'b0001, "R9 disabled limit ignored");

      tag = "R7";
      wr(3'd0, 32'h4);
      aged_contest(4'b0101, 4'b0100, "R7 aged dma wins");
      wr(3'd4, 32'h1400);
      aged_contest(4'b0101, 4'b0001, "R7 below limit no effect");

      tag = "R8";
      wr(3'd0, 32'h5);
      wr(3'd2, 32'h0201);
      wr(3'd4, 32'h0202);
      aged_contest(4'b0111, 4'b0100, "R8 urgent tie by rank");
      wr(3'd2, 32'h0203);
      aged_contest(4'b0111, 4'b0001, "R8 urgent pci higher rank");

      tag = "R10";
      do_reset();
      wr(3'd2, 32'h5A02);
      rd(3'd2, 32'h5A02, "R10 pci cfg fields");
      wr(3'd3, 32'hFFFF_FFFF);
      rd(3'd3, 32'hFF03, "R10 unused bits read zero");
      wr(3'd0, 32'hFF);
      rd(3'd0, 32'h7, "R10 enable width");
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd7, 32'hFFFF_FFFF);
      rd(3'd5, 32'h0, "R10 unmapped 5 reads zero");
      rd(3'd7, 32'h0, "R10 unmapped 7 reads zero");
      rd(3'd0, 32'h7, "R10 unmapped write no effect enable");
      rd(3'd1, 32'h0, "R10 unmapped write no effect cpu");
      rd(3'd4, 32'hFF01, "R10 unmapped write no effect dma");

      tag = "R3";
      do_reset();
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         req = 4'($urandom);
         eot = ($urandom % 6 == 0) ? 4'($urandom) : 4'b0;
         reg_we = ($urandom % 20 == 0);
         reg_addr = 3'($urandom);
         reg_wdata = {16'h0, 4'h0, 4'($urandom % 8), 8'($urandom)};
      end
      @(negedge clk);
      reg_we = 1'b0; req = '0; eot = '0;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired in %s", tag);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule